// File: doc/BRIEF.md
# Trisected Slice Multiplier (18 x 18, unsigned)

This block multiplies two unsigned 18-bit operands and returns the full 36-bit product one clock after the operands are presented. It does not build one large partial-product matrix. Each operand is cut into three 6-bit slices, and every pairing of an A slice with a B slice goes to its own 6x6 sub-multiplier. That makes nine small units working side by side with plain AND-gate partial products and no Booth recoding. Each unit leaves its result in carry-save form, as two 12-bit vectors. The eighteen vectors are placed at their slice weight, folded down to two 36-bit vectors by a row of 3:2 counters, and added by a parallel-prefix carry-propagate adder. The product is registered at the output.

The same three-way split can be applied to the 18-bit operands in turn. That would give a 54-bit multiplier built from 81 small units. This project builds only the 18-bit level.

Each small unit can also be reached on its own for exhaustive testing. While test mode is on, a select code routes the low six bits of each operand into one chosen unit. That unit's two carry-save vectors are registered on a separate test output. The product register is left alone during test mode.

Top module: `tri_split_mul`

## Requirements
- R1: When `in_valid` is 1 and `test_en` is 0 at a rising edge, at that edge `out_valid` becomes 1 and `product` becomes the exact unsigned product `op_a * op_b`, 36 bits wide.
- R2: At any rising edge where `in_valid` is 0 or `test_en` is 1, `out_valid` becomes 0 and `product` keeps its previous value. `out_valid` and `test_valid` are never 1 in the same cycle.
- R3: At a rising edge with `rst_n` at 0, `out_valid`, `test_valid`, `product`, `test_sum` and `test_carry` all become 0.
- R4: A slice is six bits: slice i of an operand is bits 6i+5 down to 6i. The sub-product of A slice i and B slice j carries weight 2^(6(i+j)). An operand pair with exactly one nonzero slice on each side therefore gives that single sub-product at that shift.
- R5: When `in_valid` and `test_en` are 1 at a rising edge and `test_sel` is 3*i+j (0 to 8, where i is the A slice and j the B slice), the selected unit multiplies `op_a[5:0]` by `op_b[5:0]`, whatever the upper operand bits are. At that edge `test_valid` becomes 1, and `test_sum + test_carry` (taken 13 bits wide) equals that 12-bit product exactly.
- R6: A test-mode request with `test_sel` in 9 to 15 still sets `test_valid` to 1, but `test_sum` and `test_carry` both become 0.
- R7: Corner operands give exact results: a zero operand gives 0, and all-ones times all-ones gives 0xFFFF80001.
- R8: Requests may arrive on every cycle. Each one gives its own result one cycle later, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe for this cycle |
| op_a | input | 18 | Multiplicand, unsigned |
| op_b | input | 18 | Multiplier, unsigned |
| test_en | input | 1 | 1: request is a sub-unit test, not a multiply |
| test_sel | input | 4 | Sub-unit select in test mode, 3*i+j |
| out_valid | output | 1 | `product` was loaded at the last edge |
| product | output | 36 | Registered product |
| test_valid | output | 1 | Test outputs were loaded at the last edge |
| test_sum | output | 12 | Sum vector of the selected sub-unit |
| test_carry | output | 12 | Carry vector of the selected sub-unit |

## Verification
Some properties are checked by assertions on every cycle. The registered product must equal the product of the operands sampled one cycle before. The two valid flags follow the request and the mode and are never high together. The product holds when no multiply is requested. A selected unit's vector pair must add up to the product of the low operand bits, and an out-of-range select must give zero vectors. Other properties can only be shown by the bench's scenarios. These are reset clearing every output, results coming out in order under back-to-back traffic, one unit tested across all 4096 input pairs, each slice pairing landing at its own weight, and the corner operands giving the stated values.

// File: rtl/tsm_pkg.sv
// tsm_pkg: shared constants and helpers for the trisected slice multiplier.
// Assumes: operands are split into equal-width slices; weights are powers of two.
package tsm_pkg;

    localparam int SLICE_W_DEF = 6;   // bits per operand slice
    localparam int NSLICE_DEF  = 3;   // slices per operand

    // Bit offset at which the sub-product of slice i (A) and slice j (B) lands.
    function automatic int slice_shift(input int i, input int j, input int w);
        return w * (i + j);
    endfunction

endpackage

// File: rtl/tsm_csa3.sv
// tsm_csa3: a row of 3:2 counters (full adders) over WIDTH bits.
// Leaves the three inputs as a sum vector and a carry vector moved up one bit.
// Assumes: the caller knows the total fits in WIDTH bits, so the carry out of
// the top bit is never needed.
module tsm_csa3 #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic [WIDTH-1:0] z,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] carry
);

    localparam int LOW = WIDTH - 1;

    // Bitwise sum of the three inputs.
    assign sum = x ^ y ^ z;

    // Majority of each bit position, moved into the next position up.
    assign carry = {(x[LOW-1:0] & y[LOW-1:0]) |
                    (x[LOW-1:0] & z[LOW-1:0]) |
                    (y[LOW-1:0] & z[LOW-1:0]), 1'b0};

endmodule

// File: rtl/tsm_slice_mul.sv
// tsm_slice_mul: W x W unsigned sub-multiplier with a carry-save result.
// It makes W AND-gate partial-product rows (no recoding) and folds them
// with a chain of 3:2 rows. The two outputs add to a*b exactly: every
// intermediate total is a partial sum of rows no larger than the product.
// Assumes: the consumer merges cs_sum and cs_carry further down the line.
module tsm_slice_mul #(
    parameter int W = 6
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] cs_sum,
    output logic [2*W-1:0] cs_carry
);

    localparam int PW = 2 * W;

    logic [W-1:0][PW-1:0] rows;
    logic [W-1:0][PW-1:0] acc_s;
    logic [W-1:0][PW-1:0] acc_c;

    genvar k;
    generate
        // Partial-product row k: a gated by b[k], at weight 2^k.
        for (k = 0; k < W; k++) begin : g_row
            assign rows[k] = PW'({W{b[k]}} & a) << k;
        end

        // The first row starts the accumulation with no carry.
        assign acc_s[0] = rows[0];
        assign acc_c[0] = '0;

        // Each later row is folded into the running sum and carry.
        for (k = 1; k < W; k++) begin : g_fold
            tsm_csa3 #(.WIDTH(PW)) u_row (
                .x     (acc_s[k-1]),
                .y     (acc_c[k-1]),
                .z     (rows[k]),
                .sum   (acc_s[k]),
                .carry (acc_c[k])
            );
        end
    endgenerate

    // The last accumulation stage is the carry-save result.
    assign cs_sum   = acc_s[W-1];
    assign cs_carry = acc_c[W-1];

endmodule

// File: rtl/tsm_csa_chain.sv
// tsm_csa_chain: folds N_IN vectors into two (sum, carry) with N_IN-2 rows
// of 3:2 counters in series.
// Assumes: N_IN >= 3 and the true total of all inputs fits in WIDTH bits.
module tsm_csa_chain #(
    parameter int N_IN  = 18,
    parameter int WIDTH = 36
) (
    input  logic [N_IN-1:0][WIDTH-1:0] vin,
    output logic [WIDTH-1:0]           red_sum,
    output logic [WIDTH-1:0]           red_carry
);

    localparam int NSTAGE = N_IN - 2;

    logic [NSTAGE:0][WIDTH-1:0] acc_s;
    logic [NSTAGE:0][WIDTH-1:0] acc_c;

    // The first two inputs seed the running pair.
    assign acc_s[0] = vin[0];
    assign acc_c[0] = vin[1];

    genvar k;
    generate
        // Stage k folds input k+1 into the running pair.
        for (k = 1; k <= NSTAGE; k++) begin : g_stage
            tsm_csa3 #(.WIDTH(WIDTH)) u_row (
                .x     (acc_s[k-1]),
                .y     (acc_c[k-1]),
                .z     (vin[k+1]),
                .sum   (acc_s[k]),
                .carry (acc_c[k])
            );
        end
    endgenerate

    // The last stage is the reduced pair.
    assign red_sum   = acc_s[NSTAGE];
    assign red_carry = acc_c[NSTAGE];

endmodule

// File: rtl/tsm_prefix_add.sv
// tsm_prefix_add: WIDTH-bit carry-propagate adder, result taken mod 2^WIDTH.
// Carries come from a parallel-prefix (log-depth) tree over generate and
// propagate. Assumes: WIDTH >= 2; no carry in; the carry out is not needed.
module tsm_prefix_add #(
    parameter int WIDTH = 36
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] total
);

    localparam int CW = WIDTH - 1;   // positions whose carry out is consumed

    // Group generate up to each bit: carry out of bit i with no carry in.
    function automatic logic [CW-1:0] prefix_carry(input logic [CW-1:0] g_in,
                                                   input logic [CW-1:0] p_in);
        logic [CW-1:0] g;
        logic [CW-1:0] p;
        logic [CW-1:0] g_nx;
        logic [CW-1:0] p_nx;
        g = g_in;
        p = p_in;
        for (int d = 1; d < CW; d = d * 2) begin
            g_nx = g;
            p_nx = p;
            for (int i = d; i < CW; i++) begin
                g_nx[i] = g[i] | (p[i] & g[i-d]);
                p_nx[i] = p[i] & p[i-d];
            end
            g = g_nx;
            p = p_nx;
        end
        return g;
    endfunction

    logic [WIDTH-1:0] prop;
    logic [CW-1:0]    gen;
    logic [CW-1:0]    cy;

    // Per-bit propagate over the full width and generate below the top bit.
    assign prop = a ^ b;
    assign gen  = a[CW-1:0] & b[CW-1:0];

    // Carry into bit i+1 for each bit i below the top.
    assign cy = prefix_carry(gen, prop[CW-1:0]);

    // Sum bits: propagate XOR incoming carry.
    assign total = prop ^ {cy, 1'b0};

endmodule

// File: rtl/tri_split_mul.sv
// tri_split_mul: unsigned (SLICE_W*NSLICE)-bit multiplier built from
// NSLICE*NSLICE small sub-multipliers, one per slice pair. The carry-save
// outputs of the sub-units are placed at their slice weight, folded to two
// vectors and summed by a prefix adder. Result registered, latency 1.
// Test mode routes the low slice of each operand into the unit picked by
// test_sel and registers that unit's raw carry-save pair.
// Assumes: synchronous active-low reset; test_sel values >= NSLICE^2 pick
// no unit.
module tri_split_mul
    import tsm_pkg::*;
#(
    parameter int SLICE_W = SLICE_W_DEF,
    parameter int NSLICE  = NSLICE_DEF
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [SLICE_W*NSLICE-1:0]           op_a,
    input  logic [SLICE_W*NSLICE-1:0]           op_b,
    input  logic                                test_en,
    input  logic [$clog2(NSLICE*NSLICE)-1:0]    test_sel,
    output logic                                out_valid,
    output logic [2*SLICE_W*NSLICE-1:0]         product,
    output logic                                test_valid,
    output logic [2*SLICE_W-1:0]                test_sum,
    output logic [2*SLICE_W-1:0]                test_carry
);

    localparam int OP_W   = SLICE_W * NSLICE;
    localparam int PROD_W = 2 * OP_W;
    localparam int SUB_W  = 2 * SLICE_W;
    localparam int NSUB   = NSLICE * NSLICE;
    localparam int NVEC   = 2 * NSUB;
    localparam int SEL_W  = $clog2(NSUB);

    logic [NSUB-1:0][SUB_W-1:0]  sub_s;
    logic [NSUB-1:0][SUB_W-1:0]  sub_c;
    logic [NVEC-1:0][PROD_W-1:0] placed;
    logic [PROD_W-1:0]           red_sum;
    logic [PROD_W-1:0]           red_carry;
    logic [PROD_W-1:0]           prod_nxt;
    logic [SUB_W-1:0]            tsel_s;
    logic [SUB_W-1:0]            tsel_c;
    logic                        do_mul;
    logic                        do_test;

    assign do_mul  = in_valid && !test_en;
    assign do_test = in_valid && test_en;

    genvar ia, jb;
    generate
        for (ia = 0; ia < NSLICE; ia++) begin : g_a
            for (jb = 0; jb < NSLICE; jb++) begin : g_b
                localparam int IDX   = ia * NSLICE + jb;
                localparam int SHIFT = slice_shift(ia, jb, SLICE_W);

                logic               hit;
                logic [SLICE_W-1:0] sa;
                logic [SLICE_W-1:0] sb;

                // Test mode redirects the low operand slices into this unit.
                assign hit = test_en && (test_sel == SEL_W'(IDX));
                assign sa  = hit ? op_a[SLICE_W-1:0] : op_a[ia*SLICE_W +: SLICE_W];
                assign sb  = hit ? op_b[SLICE_W-1:0] : op_b[jb*SLICE_W +: SLICE_W];

                tsm_slice_mul #(.W(SLICE_W)) u_sub (
                    .a        (sa),
                    .b        (sb),
                    .cs_sum   (sub_s[IDX]),
                    .cs_carry (sub_c[IDX])
                );

                // Place both carry-save vectors at the slice pair's weight.
                assign placed[2*IDX]   = PROD_W'(sub_s[IDX]) << SHIFT;
                assign placed[2*IDX+1] = PROD_W'(sub_c[IDX]) << SHIFT;
            end
        end
    endgenerate

    tsm_csa_chain #(.N_IN(NVEC), .WIDTH(PROD_W)) u_reduce (
        .vin       (placed),
        .red_sum   (red_sum),
        .red_carry (red_carry)
    );

    tsm_prefix_add #(.WIDTH(PROD_W)) u_final (
        .a     (red_sum),
        .b     (red_carry),
        .total (prod_nxt)
    );

    // Select the carry-save pair of the unit under test; zero if none.
    always_comb begin
        tsel_s = '0;
        tsel_c = '0;
        for (int k = 0; k < NSUB; k++) begin
            if (test_sel == SEL_W'(k)) begin
                tsel_s = sub_s[k];
                tsel_c = sub_c[k];
            end
        end
    end

    // Product register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= do_mul;
            if (do_mul) begin
                product <= prod_nxt;
            end
        end
    end

    // Test observation registers and their valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_valid <= 1'b0;
            test_sum   <= '0;
            test_carry <= '0;
        end else begin
            test_valid <= do_test;
            if (do_test) begin
                test_sum   <= tsel_s;
                test_carry <= tsel_c;
            end
        end
    end

endmodule

// File: rtl/tri_split_mul_chk.sv
// tri_split_mul_chk: protocol and arithmetic checks for tri_split_mul,
// attached by bind. Observes ports only.
module tri_split_mul_chk #(
    parameter int SLICE_W = 6,
    parameter int NSLICE  = 3
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                in_valid,
    input logic [SLICE_W*NSLICE-1:0]           op_a,
    input logic [SLICE_W*NSLICE-1:0]           op_b,
    input logic                                test_en,
    input logic [$clog2(NSLICE*NSLICE)-1:0]    test_sel,
    input logic                                out_valid,
    input logic [2*SLICE_W*NSLICE-1:0]         product,
    input logic                                test_valid,
    input logic [2*SLICE_W-1:0]                test_sum,
    input logic [2*SLICE_W-1:0]                test_carry
);

    localparam int PROD_W = 2 * SLICE_W * NSLICE;
    localparam int SUB_W  = 2 * SLICE_W;
    localparam int NSUB   = NSLICE * NSLICE;
    localparam int SEL_W  = $clog2(NSUB);

    logic [SUB_W:0] t_total;

    // Full-width total of the observed carry-save pair.
    assign t_total = {1'b0, test_sum} + {1'b0, test_carry};

    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> product == PROD_W'($past(op_a)) * PROD_W'($past(op_b))); // R1

    AST_MUL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !test_en) |=> out_valid); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !test_en) |=> !out_valid && $stable(product)); // R2

    AST_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && test_valid)); // R2

    AST_TEST_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (test_valid && ($past(test_sel) < SEL_W'(NSUB))) |->
        t_total == (SUB_W+1)'($past(op_a[SLICE_W-1:0])) * (SUB_W+1)'($past(op_b[SLICE_W-1:0]))); // R5

    AST_TEST_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (test_valid && ($past(test_sel) >= SEL_W'(NSUB))) |->
        (test_sum == '0 && test_carry == '0)); // R6

endmodule

bind tri_split_mul tri_split_mul_chk #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_chk (.*);

// File: tb/test_tri_split_mul.sv
`timescale 1ns/1ps
// test_tri_split_mul: scoreboard bench. Driver tasks push expected items;
// a monitor pops them when a valid output appears.
module test_tri_split_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] op_a = '0;
    logic [17:0] op_b = '0;
    logic        test_en = 1'b0;
    logic [3:0]  test_sel = '0;
    logic        out_valid;
    logic [35:0] product;
    logic        test_valid;
    logic [11:0] test_sum;
    logic [11:0] test_carry;

    typedef struct {
        int          kind;   // 0 product, 1 test unit, 2 test none
        int          req;
        logic [35:0] exp;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    tri_split_mul i_tri_split_mul (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_a       (op_a),
        .op_b       (op_b),
        .test_en    (test_en),
        .test_sel   (test_sel),
        .out_valid  (out_valid),
        .product    (product),
        .test_valid (test_valid),
        .test_sum   (test_sum),
        .test_carry (test_carry)
    );

    task automatic check(input int req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one multiply request.
    task automatic drive_mul(input logic [17:0] a, input logic [17:0] b, input int req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; test_en = 1'b0; op_a = a; op_b = b;
        it.kind = 0; it.req = req; it.exp = 36'(a) * 36'(b);
        exp_q.push_back(it);
    endtask

    // Driver: one sub-unit test request.
    task automatic drive_test(input logic [3:0] sel, input logic [17:0] a, input logic [17:0] b);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; test_en = 1'b1; test_sel = sel; op_a = a; op_b = b;
        if (sel < 4'd9) begin
            it.kind = 1; it.req = 5; it.exp = 36'(a[5:0]) * 36'(b[5:0]);   // R5
        end else begin
            it.kind = 2; it.req = 6; it.exp = '0;                          // R6
        end
        exp_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; test_en = 1'b0;
        end
    endtask

    // Monitor: compares every valid output with the oldest expected item.
    always @(negedge clk) begin
        #1;
        if (rst_n && (out_valid || test_valid)) begin
            if (exp_q.size() == 0) begin
                check(2, {35'd0, out_valid}, 36'd0);   // R2: valid with nothing pending
            end else begin
                item_t it;
                it = exp_q.pop_front();
                if (it.kind == 0) begin
                    check(8, {35'd0, out_valid}, 36'd1);   // R8 order/kind
                    check(it.req, product, it.exp);
                end else if (it.kind == 1) begin
                    check(5, {35'd0, test_valid}, 36'd1);
                    check(5, 36'(test_sum) + 36'(test_carry), it.exp);
                end else begin
                    check(6, {35'd0, test_valid}, 36'd1);
                    check(6, {12'd0, test_sum, test_carry}, 36'd0);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [35:0] held;
        // R3: reset clears all outputs even with a request present.
        in_valid = 1'b1; op_a = 18'h3FFFF; op_b = 18'h3FFFF; test_en = 1'b0;
        repeat (3) @(negedge clk);
        check(3, {35'd0, out_valid}, 36'd0);
        check(3, {35'd0, test_valid}, 36'd0);
        check(3, product, 36'd0);
        check(3, {12'd0, test_sum, test_carry}, 36'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R7: corner operands.
        drive_mul(18'h00000, 18'h3FFFF, 7);
        drive_mul(18'h3FFFF, 18'h00000, 7);
        drive_mul(18'h3FFFF, 18'h3FFFF, 7);
        drive_mul(18'h3FFFF, 18'h00001, 7);
        idle(3);
        drive_mul(18'h3FFFF, 18'h3FFFF, 7);
        idle(1);
        #1 check(7, product, 36'hFFFF80001);   // R7 explicit value

        // R4: one nonzero slice on each side lands at weight 6*(i+j).
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                drive_mul(18'(18'h2B) << (6*i), 18'(18'h3F) << (6*j), 4);
            end
        end
        idle(3);

        // R1, R8: back-to-back random operands.
        for (int n = 0; n < 300; n++) begin
            drive_mul(18'($urandom), 18'($urandom), 1);
        end
        idle(3);

        // R2: product holds over idle and test-mode cycles.
        drive_mul(18'h12345, 18'h2ABCD, 1);
        idle(2);
        held = 36'(18'h12345) * 36'(18'h2ABCD);
        for (int s = 0; s < 16; s++) begin
            drive_test(4'(s), 18'($urandom), 18'($urandom));   // R5, R6
        end
        idle(3);
        #1 check(2, product, held);
        check(2, {35'd0, out_valid}, 36'd0);

        // R5: exhaustive run of the centre unit, upper bits random.
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                drive_test(4'd4, {12'($urandom), 6'(x)}, {12'($urandom), 6'(y)});
            end
        end
        // R5: extremes on every unit.
        for (int s = 0; s < 9; s++) begin
            drive_test(4'(s), 18'h3FFFF, 18'h3FFFF);
            drive_test(4'(s), 18'h3FFC0, 18'h3FFC1);
        end
        // R6: out-of-range selects.
        for (int s = 9; s < 16; s++) begin
            drive_test(4'(s), 18'h3FFFF, 18'h3FFFF);
        end
        // R8: mixed interleaving of tests and multiplies.
        for (int n = 0; n < 40; n++) begin
            drive_mul(18'($urandom), 18'($urandom), 8);
            drive_test(4'($urandom_range(0, 15)), 18'($urandom), 18'($urandom));
        end
        idle(4);
        check(8, 36'(exp_q.size()), 36'd0);   // R8: every request answered

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule